// File: doc/BRIEF.md
# Mosaic Source-Line Generator

This block produces, for each of four background layers, the vertical source line that a tile fetcher should use when a blocky mosaic effect is active. On every line-start strobe it either copies the current display line into a layer's effective-line register or leaves the register unchanged. While a mosaic block is in progress, an enabled layer keeps repeating the line at the top of the block. The choice is made by the layer's own mosaic enable and by one countdown that all four layers share. The countdown is reloaded from a 4-bit block size.

A purely combinational helper goes with it. It rounds a 12-bit horizontal coordinate down to the nearest multiple of (size+1), so the same block size also applies across a line. The fetcher reads the four effective lines and the rounded X. Fetching and pixel output sit outside this block.

Top module: `mosaic_line_gen`

## Requirements
- R1: After reset all four effective lines read 0 and the shared countdown is 0, so the first strobe on a line other than 1 loads the line number into every layer.
- R2: A strobe with line number 1 sets all four effective lines to 1 and loads the countdown with the current mosaic size.
- R3: On a strobe with any line number other than 1, a layer whose enable bit (bit i of the enable input drives layer i) is 0 takes the line number.
- R4: On a strobe with a line number other than 1, an enabled layer takes the line number only if the countdown is 0. Otherwise it keeps its value.
- R5: On a strobe with a line number other than 1, the countdown becomes the mosaic size if it was 0, and otherwise drops by one. Enabled layers therefore change every size+1 lines, counted from line 1.
- R6: Without a strobe, the effective lines and the countdown keep their values.
- R7: The quantiser output equals floor(x/(size+1))*(size+1) for every 12-bit x and every size from 0 to 15.
- R8: A change of mosaic size in the middle of a block does not shorten or lengthen that block. The new size takes effect at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStart | input | 1 | One-cycle strobe at the start of each line |
| lineNum | input | 9 | Current display line number |
| mosaicSize | input | 4 | Mosaic block size minus one |
| layerMosaicEn | input | 4 | Per-layer mosaic enable, bit i for layer i |
| quantX | input | 12 | Horizontal coordinate to be rounded |
| quantXOut | output | 12 | quantX rounded down to a multiple of size+1 |
| effLine | output | 4x9 | Effective source line per layer, layer i in slice i |

## Verification
The bench builds the block with its default parameters: four layers, 9-bit lines, a 4-bit size and a 12-bit X. With a 4-bit size, every block height from 1 to 16 can be reached. Every size is swept in the quantiser, including the largest X of 4095. With 9-bit lines, frames run past several whole blocks, including the size-0 case in which every line updates. Directed frames mix enabled and disabled layers, change the size in the middle of a block, and strobe a line other than 1 straight after reset.

// File: rtl/mosaic_pkg.sv
package mosaic_pkg;
  typedef struct packed {
    logic firstLine;  // strobe on line 1
    logic laterLine;  // strobe on any other line
    logic blockEdge;  // countdown is zero at this strobe
  } mosaicStrobe_t;
endpackage

// File: rtl/mosaic_ctrl.sv
module mosaic_ctrl #(
  parameter int LINE_W = 9,
  parameter int SIZE_W = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       lineStart,
  input  logic [LINE_W-1:0]          lineNum,
  input  logic [SIZE_W-1:0]          mosaicSize,
  output mosaic_pkg::mosaicStrobe_t  strobe
);
  logic [SIZE_W-1:0] countdown;
  logic [SIZE_W-1:0] countdownNext;
  logic              isLineOne;

  assign isLineOne = (lineNum == LINE_W'(1));

  always_comb begin
    strobe.firstLine = lineStart && isLineOne;
    strobe.laterLine = lineStart && !isLineOne;
    strobe.blockEdge = (countdown == '0);
  end

  always_comb begin
    countdownNext = countdown;
    if (strobe.firstLine) begin
      countdownNext = mosaicSize;
    end else if (strobe.laterLine) begin
      if (countdown == '0) countdownNext = mosaicSize;
      else                 countdownNext = countdown - SIZE_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) countdown <= '0;
    else       countdown <= countdownNext;
  end

  // R2
  cnt_line_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && lineNum == LINE_W'(1)) |=> countdown == $past(mosaicSize));
  // R5
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && lineNum != LINE_W'(1) && countdown == '0) |=> countdown == $past(mosaicSize));
  // R5
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && lineNum != LINE_W'(1) && countdown != '0) |=> countdown == $past(countdown) - SIZE_W'(1));
  // R6
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineStart |=> $stable(countdown));
endmodule

// File: rtl/mosaic_line_dp.sv
module mosaic_line_dp #(
  parameter int NUM_LAYERS = 4,
  parameter int LINE_W     = 9
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  mosaic_pkg::mosaicStrobe_t              strobe,
  input  logic [LINE_W-1:0]                      lineNum,
  input  logic [NUM_LAYERS-1:0]                  layerMosaicEn,
  output logic [NUM_LAYERS-1:0][LINE_W-1:0]      effLine
);
  for (genvar i = 0; i < NUM_LAYERS; i++) begin : gLayer
    logic takeLine;
    assign takeLine = strobe.laterLine && (!layerMosaicEn[i] || strobe.blockEdge);

    always_ff @(posedge clk) begin
      if (!rstN)                 effLine[i] <= '0;
      else if (strobe.firstLine) effLine[i] <= LINE_W'(1);
      else if (takeLine)         effLine[i] <= lineNum;
    end

    // R3
    layer_track_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.laterLine && !layerMosaicEn[i]) |=> effLine[i] == $past(lineNum));
    // R4
    layer_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.laterLine && layerMosaicEn[i] && !strobe.blockEdge) |=> $stable(effLine[i]));
  end

  // R2
  line_one_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.firstLine |=> effLine == {NUM_LAYERS{LINE_W'(1)}});
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.firstLine || strobe.laterLine) |=> $stable(effLine));
endmodule

// File: rtl/mosaic_xquant.sv
module mosaic_xquant #(
  parameter int X_W    = 12,
  parameter int SIZE_W = 4
) (
  input  logic [X_W-1:0]    quantX,
  input  logic [SIZE_W-1:0] mosaicSize,
  output logic [X_W-1:0]    quantXOut
);
  localparam int NUM_SIZES = 1 << SIZE_W;

  logic [X_W-1:0] candidate [NUM_SIZES];

  for (genvar s = 0; s < NUM_SIZES; s++) begin : gSize
    localparam int BLK = s + 1;
    assign candidate[s] = X_W'((32'(quantX) / BLK) * BLK);
  end

  assign quantXOut = candidate[mosaicSize];

  always_comb begin
    // R7
    quant_bound_chk: assert ((quantXOut <= quantX) &&
                             ((quantX - quantXOut) <= X_W'(mosaicSize)));
  end
endmodule

// File: rtl/mosaic_line_gen.sv
module mosaic_line_gen #(
  parameter int NUM_LAYERS = 4,
  parameter int LINE_W     = 9,
  parameter int SIZE_W     = 4,
  parameter int X_W        = 12
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              lineStart,
  input  logic [LINE_W-1:0]                 lineNum,
  input  logic [SIZE_W-1:0]                 mosaicSize,
  input  logic [NUM_LAYERS-1:0]             layerMosaicEn,
  input  logic [X_W-1:0]                    quantX,
  output logic [X_W-1:0]                    quantXOut,
  output logic [NUM_LAYERS-1:0][LINE_W-1:0] effLine
);
  mosaic_pkg::mosaicStrobe_t strobe;

  mosaic_ctrl #(.LINE_W(LINE_W), .SIZE_W(SIZE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .lineNum(lineNum),
    .mosaicSize(mosaicSize), .strobe(strobe)
  );

  mosaic_line_dp #(.NUM_LAYERS(NUM_LAYERS), .LINE_W(LINE_W)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineNum(lineNum),
    .layerMosaicEn(layerMosaicEn), .effLine(effLine)
  );

  mosaic_xquant #(.X_W(X_W), .SIZE_W(SIZE_W)) uQuant (
    .quantX(quantX), .mosaicSize(mosaicSize), .quantXOut(quantXOut)
  );
endmodule

// File: tb/tb_mosaic_line_gen.sv
module tb_mosaic_line_gen;
  localparam int NL = 4;
  localparam int LW = 9;
  localparam int SW = 4;
  localparam int XW = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStart = 1'b0;
  logic [LW-1:0] lineNum = '0;
  logic [SW-1:0] mosaicSize = '0;
  logic [NL-1:0] layerMosaicEn = '0;
  logic [XW-1:0] quantX = '0;
  logic [XW-1:0] quantXOut;
  logic [NL-1:0][LW-1:0] effLine;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  int mCnt;
  int mEff [NL];

  always #4 clk = ~clk;

  mosaic_line_gen dut (
    .clk(clk), .rstN(rstN), .lineStart(lineStart), .lineNum(lineNum),
    .mosaicSize(mosaicSize), .layerMosaicEn(layerMosaicEn),
    .quantX(quantX), .quantXOut(quantXOut), .effLine(effLine)
  );

  task automatic check(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic checkAll(string tagOn, string tagOff);
    for (int i = 0; i < NL; i++)
      check(layerMosaicEn[i] ? tagOn : tagOff, int'(effLine[i]), mEff[i]);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    lineStart = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mCnt = 0;
    for (int i = 0; i < NL; i++) mEff[i] = 0;
  endtask

  // Reference update, written from R2..R5
  task automatic modelLine(int n);
    bit zero;
    if (n == 1) begin
      for (int i = 0; i < NL; i++) mEff[i] = 1;
      mCnt = int'(mosaicSize);
    end else begin
      zero = (mCnt == 0);
      for (int i = 0; i < NL; i++)
        if (!layerMosaicEn[i] || zero) mEff[i] = n;
      mCnt = zero ? int'(mosaicSize) : mCnt - 1;
    end
  endtask

  task automatic applyLine(int n);
    lineNum = LW'(n);
    lineStart = 1'b1;
    @(negedge clk);
    lineStart = 1'b0;
    modelLine(n);
  endtask

  task automatic testReset();
    doReset();
    for (int i = 0; i < NL; i++) check("R1 reset value", int'(effLine[i]), 0);
    layerMosaicEn = '1;
    mosaicSize = 4'd5;
    applyLine(37);
    for (int i = 0; i < NL; i++) check("R1 first strobe", int'(effLine[i]), 37);
  endtask

  task automatic testFrame(int size, logic [NL-1:0] en, int lines);
    doReset();
    mosaicSize = SW'(size);
    layerMosaicEn = en;
    for (int n = 1; n <= lines; n++) begin
      applyLine(n);
      if (n == 1) checkAll("R2", "R2");
      else        checkAll("R4", "R3");
    end
  endtask

  task automatic testBlockHeight();
    int expSeq [8] = '{1, 1, 1, 4, 4, 4, 7, 7};
    doReset();
    mosaicSize = 4'd2;
    layerMosaicEn = '1;
    for (int n = 1; n <= 8; n++) begin
      applyLine(n);
      check("R5 block height", int'(effLine[0]), expSeq[n-1]);
    end
  endtask

  task automatic testIdle();
    logic [NL-1:0][LW-1:0] snap;
    doReset();
    mosaicSize = 4'd3;
    layerMosaicEn = 4'b0110;
    for (int n = 1; n <= 3; n++) applyLine(n);
    snap = effLine;
    lineNum = 9'd200;
    mosaicSize = 4'd0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < NL; i++) check("R6 idle hold", int'(effLine[i]), int'(snap[i]));
    mosaicSize = 4'd3;
    applyLine(4);
    checkAll("R6 countdown kept", "R6 countdown kept");
  endtask

  task automatic testSizeChange();
    int expSeq [7] = '{1, 1, 1, 1, 5, 5, 7};
    doReset();
    mosaicSize = 4'd3;
    layerMosaicEn = 4'b1011;
    applyLine(1);
    check("R8 start", int'(effLine[0]), 1);
    mosaicSize = 4'd1;
    for (int n = 2; n <= 7; n++) begin
      applyLine(n);
      check("R8 size change", int'(effLine[0]), expSeq[n-1]);
      checkAll("R8", "R3");
    end
  endtask

  task automatic testQuant();
    int xs [6] = '{0, 1, 17, 1000, 4094, 4095};
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        mosaicSize = SW'(s);
        quantX = XW'(xs[k]);
        #1;
        check("R7 quantiser", int'(quantXOut), (xs[k] / (s + 1)) * (s + 1));
      end
    end
  endtask

  initial begin
    testReset();
    testFrame(0, 4'b1111, 12);
    testFrame(3, 4'b0101, 30);
    testFrame(15, 4'b1110, 40);
    testBlockHeight();
    testIdle();
    testSizeChange();
    testQuant();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule